// File: doc/BRIEF.md
# Transmit Buffer Fill and Launch Controller

This block sits between a bus-master DMA engine and a MAC serializer. It owns a byte-wide transmit buffer of 272 entries. It counts the bytes held and the space left, and it asks the DMA side for more data when the free space reaches a chosen level. It also tells the MAC when the frame at the head of the buffer may start. The MAC may start once enough bytes of that frame are present. If the frame's last byte is already stored, the MAC may start at once, whatever the byte count.

Space taken by a frame is not returned when its bytes are read. It is returned only when the MAC reports the frame finished or discards it. This lets a collision retry go back to the first byte of the frame and send it again from the buffer, with no second fetch from memory. The read side can rewind to the frame start at any time. A discard drops the head frame. If that frame is still being written, the rest of it is thrown away as it arrives from the DMA side.

Top module: `txf_thresh_ctrl`

## Requirements
- R1: After reset the buffer is empty: `fillCount`=0, `rdValid`=0, `txGo`=0, `dmaReq`=1 and `wrReady`=1.
- R2: `dmaReq` is high exactly when (272 − `fillCount`) is at least the free-space mark selected by `cfgMark`: 00=16, 01=32, 10=64, 11=128 bytes.
- R3: While the buffer holds no complete frame, `txGo` is high exactly when the bytes stored for the head frame reach the count selected by `cfgStart`: 00=16, 01=64, 10=128.
- R4: In the cycle after a byte written with `wrLast`=1 is accepted, `txGo` is high for every `cfgStart` setting, even if the frame is shorter than the start count.
- R5: With `cfgStart`=11, `txGo` stays low until the head frame's last byte is stored.
- R6: Bytes come out on `rdData` in the order they were written. `rdLast` is 1 only on a frame's final byte.
- R7: A `rewind` pulse returns the read side to the first byte of the head frame, which can then be read again. `fillCount` does not change.
- R8: Reading bytes does not lower `fillCount`. A `frameDone` pulse lowers it by the head frame's full length.
- R9: A `flush` pulse while at least one complete frame is stored removes the head frame. The next frame's bytes are read next.
- R10: A `flush` pulse while only a partial frame is stored empties the buffer. The write side keeps `wrReady` high and drops every later byte up to and including the one marked `wrLast`.
- R11: When `fillCount` is 272, `wrReady` is low and a byte offered on the write side is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 2 | Start-count select |
| cfgMark | input | 2 | Free-space mark select |
| wrValid | input | 1 | DMA side offers a byte |
| wrData | input | 8 | Byte offered |
| wrLast | input | 1 | Offered byte ends its frame |
| wrReady | output | 1 | Byte is taken this cycle |
| dmaReq | output | 1 | Request for more data from memory |
| txGo | output | 1 | Head frame may begin on the wire |
| rdEn | input | 1 | MAC takes the byte on rdData |
| rdData | output | 8 | Byte at the read position |
| rdLast | output | 1 | rdData is the final byte of its frame |
| rdValid | output | 1 | A stored byte is at the read position |
| frameDone | input | 1 | Head frame has been sent; free its space |
| rewind | input | 1 | Return to head frame start for a retry |
| flush | input | 1 | Discard the head frame |
| fillCount | output | 9 | Bytes held, including bytes already read |

## Verification
The hardest state to reach from the ports is the drop mode: a partial frame discarded while its writer is still sending. The stimulus first fills the whole 272-byte buffer with one unterminated frame and checks the outputs at every fill level. It then offers one byte to the full buffer, discards the partial frame, and feeds the rest of that frame. Next it checks that nothing was stored and that the next frame arrives intact. Rewind is also tested in the middle of a frame, after part of it has been read.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Strobes from the control side to the storage side, one cycle each.
  typedef struct packed {
    logic wr;      // store the byte on the write side
    logic rd;      // advance the read position by one
    logic rewind;  // read position back to head frame start
    logic free;    // return relLen bytes at the head to free space
  } txfStrobeT;

endpackage

// File: rtl/txf_store.sv
module txf_store
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH = 272,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  txfStrobeT     stb,
  input  logic [7:0]    wrData,
  input  logic          wrLast,
  input  logic [CW-1:0] relLen,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] readable,
  output logic [7:0]    rdData,
  output logic          rdLast
);

  localparam int unsigned SW = CW + 1;
  localparam logic [SW-1:0] DEPTH_S = SW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, basePtr;
  logic [CW-1:0] occNext;
  logic [AW-1:0] baseNext;

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] skipPtr(input logic [AW-1:0] p,
                                            input logic [CW-1:0] n);
    logic [SW-1:0] s;
    s = SW'(p) + SW'(n);
    if (s >= DEPTH_S) s = s - DEPTH_S;
    return s[AW-1:0];
  endfunction

  always_comb begin
    occNext  = occ + CW'(stb.wr) - (stb.free ? relLen : '0);
    baseNext = stb.free ? skipPtr(basePtr, relLen) : basePtr;
  end

  always_ff @(posedge clk) begin
    if (stb.wr) mem[wrPtr] <= {wrLast, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      basePtr  <= '0;
      occ      <= '0;
      readable <= '0;
    end else begin
      if (stb.wr) wrPtr <= stepPtr(wrPtr);
      basePtr <= baseNext;
      occ     <= occNext;
      if (stb.free || stb.rewind) begin
        rdPtr    <= baseNext;
        readable <= occNext;
      end else begin
        if (stb.rd) rdPtr <= stepPtr(rdPtr);
        readable <= readable + CW'(stb.wr) - CW'(stb.rd);
      end
    end
  end

  assign {rdLast, rdData} = mem[rdPtr];

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |-> occ < CW'(DEPTH));

  // R7
  rewind_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rewind |=> readable == occ);

  // R8
  read_keeps_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && !stb.wr && !stb.free) |=> occ == $past(occ));

  // R6
  read_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    readable <= occ);

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH  = 272,
  parameter int unsigned QD     = 4,
  parameter int unsigned START0 = 16,
  parameter int unsigned START1 = 64,
  parameter int unsigned START2 = 128,
  parameter int unsigned MARK0  = 16,
  parameter int unsigned MARK1  = 32,
  parameter int unsigned MARK2  = 64,
  parameter int unsigned MARK3  = 128,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    cfgStart,
  input  logic [1:0]    cfgMark,
  input  logic          wrValid,
  input  logic          wrLast,
  input  logic          rdEn,
  input  logic          frameDone,
  input  logic          rewind,
  input  logic          flush,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] readable,
  output txfStrobeT     stb,
  output logic [CW-1:0] relLen,
  output logic          wrReady,
  output logic          dmaReq,
  output logic          txGo,
  output logic          rdValid
);

  localparam int unsigned QW = (QD > 1) ? $clog2(QD) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [QW:0]   QD_C    = (QW + 1)'(QD);

  logic [CW-1:0] lenQ [QD];
  logic [QW-1:0] qHead, qTail;
  logic [QW:0]   qCnt;
  logic [CW-1:0] curLen;
  logic          dropping;

  logic          wrAcc, headFlush, partFlush, doneOk, qPush, qPop;
  logic [CW-1:0] startThr, markThr, freeCnt;

  always_comb begin
    case (cfgStart)
      2'b00:   startThr = CW'(START0);
      2'b01:   startThr = CW'(START1);
      default: startThr = CW'(START2);
    endcase
    case (cfgMark)
      2'b00:   markThr = CW'(MARK0);
      2'b01:   markThr = CW'(MARK1);
      2'b10:   markThr = CW'(MARK2);
      default: markThr = CW'(MARK3);
    endcase
  end

  always_comb begin
    wrReady   = dropping || (occ < DEPTH_C && qCnt < QD_C);
    wrAcc     = wrValid && wrReady;
    headFlush = flush && (qCnt != '0);
    partFlush = flush && (qCnt == '0) && (curLen != '0);
    doneOk    = frameDone && !flush && (qCnt != '0);
    rdValid   = readable != '0;

    stb.free   = headFlush || partFlush || doneOk;
    stb.wr     = wrAcc && !dropping && !partFlush;
    stb.rewind = rewind && !stb.free;
    stb.rd     = rdEn && rdValid && !stb.free && !rewind;
    relLen     = partFlush ? curLen : lenQ[qHead];

    qPush = stb.wr && wrLast;
    qPop  = headFlush || doneOk;

    freeCnt = DEPTH_C - occ;
    dmaReq  = freeCnt >= markThr;
    txGo    = (qCnt != '0) || ((cfgStart != 2'b11) && (curLen >= startThr));
  end

  always_ff @(posedge clk) begin
    if (qPush) lenQ[qTail] <= curLen + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qHead    <= '0;
      qTail    <= '0;
      qCnt     <= '0;
      curLen   <= '0;
      dropping <= 1'b0;
    end else begin
      if (qPush) qTail <= qTail + 1'b1;
      if (qPop)  qHead <= qHead + 1'b1;
      qCnt <= qCnt + (QW + 1)'(qPush) - (QW + 1)'(qPop);

      if (partFlush)   curLen <= '0;
      else if (stb.wr) curLen <= wrLast ? '0 : curLen + 1'b1;

      if (partFlush)                       dropping <= !(wrAcc && wrLast);
      else if (dropping && wrAcc && wrLast) dropping <= 1'b0;
    end
  end

  // R2
  mark_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (DEPTH_C - occ) < CW'(MARK0) |-> !dmaReq);

  // R4
  frame_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && wrLast) |=> txGo);

  // R3
  start_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txGo && qCnt == '0) |-> curLen >= CW'(START0));

  // R8
  free_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.free |-> (relLen != '0 && relLen <= occ));

  // R10
  drop_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropping |-> (!stb.wr && occ == '0));

  // R9
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    qCnt <= QD_C);

endmodule

// File: rtl/txf_thresh_ctrl.sv
module txf_thresh_ctrl
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH  = 272,
  parameter int unsigned QD     = 4,
  parameter int unsigned START0 = 16,
  parameter int unsigned START1 = 64,
  parameter int unsigned START2 = 128,
  parameter int unsigned MARK0  = 16,
  parameter int unsigned MARK1  = 32,
  parameter int unsigned MARK2  = 64,
  parameter int unsigned MARK3  = 128,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    cfgStart,
  input  logic [1:0]    cfgMark,
  input  logic          wrValid,
  input  logic [7:0]    wrData,
  input  logic          wrLast,
  output logic          wrReady,
  output logic          dmaReq,
  output logic          txGo,
  input  logic          rdEn,
  output logic [7:0]    rdData,
  output logic          rdLast,
  output logic          rdValid,
  input  logic          frameDone,
  input  logic          rewind,
  input  logic          flush,
  output logic [CW-1:0] fillCount
);

  txfStrobeT     stb;
  logic [CW-1:0] relLen, occ, readable;

  txf_ctrl #(
    .DEPTH(DEPTH), .QD(QD),
    .START0(START0), .START1(START1), .START2(START2),
    .MARK0(MARK0), .MARK1(MARK1), .MARK2(MARK2), .MARK3(MARK3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgMark(cfgMark),
    .wrValid(wrValid), .wrLast(wrLast), .rdEn(rdEn),
    .frameDone(frameDone), .rewind(rewind), .flush(flush),
    .occ(occ), .readable(readable), .stb(stb), .relLen(relLen),
    .wrReady(wrReady), .dmaReq(dmaReq), .txGo(txGo), .rdValid(rdValid)
  );

  txf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .wrLast(wrLast),
    .relLen(relLen), .occ(occ), .readable(readable),
    .rdData(rdData), .rdLast(rdLast)
  );

  assign fillCount = occ;

endmodule

// File: tb/txf_thresh_ctrl_bench.sv
`timescale 1ns/100ps
module txf_thresh_ctrl_bench;

  localparam int DEPTH = 272;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgStart = 2'b01, cfgMark = 2'b00;
  logic       wrValid = 0, wrLast = 0, rdEn = 0, frameDone = 0, rewind = 0, flush = 0;
  logic [7:0] wrData = '0;
  logic       wrReady, dmaReq, txGo, rdLast, rdValid;
  logic [7:0] rdData;
  logic [8:0] fillCount;

  int total = 0, bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  txf_thresh_ctrl u_txf_thresh_ctrl (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgMark(cfgMark),
    .wrValid(wrValid), .wrData(wrData), .wrLast(wrLast), .wrReady(wrReady),
    .dmaReq(dmaReq), .txGo(txGo), .rdEn(rdEn), .rdData(rdData),
    .rdLast(rdLast), .rdValid(rdValid), .frameDone(frameDone),
    .rewind(rewind), .flush(flush), .fillCount(fillCount)
  );

  function automatic logic [7:0] pat(input int id, input int i);
    return 8'((id * 37 + i * 3 + 1) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic put(input logic [7:0] d, input logic l);
    wrValid = 1; wrData = d; wrLast = l;
    @(negedge clk);
    wrValid = 0; wrLast = 0;
  endtask

  task automatic take(input string req, input logic [7:0] d, input logic l);
    chk({req, " rdValid"}, int'(rdValid), 1);
    chk({req, " rdData"}, int'(rdData), int'(d));
    chk({req, " rdLast"}, int'(rdLast), int'(l));
    rdEn = 1;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic pulseDone();
    frameDone = 1; @(negedge clk); frameDone = 0;
  endtask
  task automatic pulseFlush();
    flush = 1; @(negedge clk); flush = 0;
  endtask
  task automatic pulseRewind();
    rewind = 1; @(negedge clk); rewind = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    finishRun();
  end

  initial begin
    int startTab[3];
    int markTab[4];
    startTab = '{16, 64, 128};
    markTab  = '{16, 32, 64, 128};

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fillCount", int'(fillCount), 0);
    chk("R1 rdValid", int'(rdValid), 0);
    chk("R1 txGo", int'(txGo), 0);
    chk("R1 dmaReq", int'(dmaReq), 1);
    chk("R1 wrReady", int'(wrReady), 1);

    // R2 R3 R5 R11: sweep every fill level of one unterminated frame
    for (int lvl = 1; lvl <= DEPTH; lvl++) begin
      put(pat(0, lvl - 1), 1'b0);
      chk("R8 fillCount", int'(fillCount), lvl);
      chk("R11 wrReady", int'(wrReady), (lvl < DEPTH) ? 1 : 0);
      for (int k = 0; k < 4; k++) begin
        cfgStart = 2'(k); cfgMark = 2'(k);
        #0.2;
        chk("R2 dmaReq", int'(dmaReq), ((DEPTH - lvl) >= markTab[k]) ? 1 : 0);
        if (k < 3) chk("R3 txGo", int'(txGo), (lvl >= startTab[k]) ? 1 : 0);
        else       chk("R5 txGo", int'(txGo), 0);
      end
      cfgStart = 2'b01; cfgMark = 2'b00;
    end

    // R11 a byte offered to the full buffer is not stored
    put(8'hAA, 1'b1);
    chk("R11 fillCount", int'(fillCount), DEPTH);
    chk("R11 txGo no frame end", int'(txGo), 1);
    cfgStart = 2'b11; #0.2;
    chk("R11 last not stored", int'(txGo), 0);
    cfgStart = 2'b01;

    // R6 R8 reading does not free space
    for (int i = 0; i < 3; i++) take("R6 sweep frame", pat(0, i), 1'b0);
    chk("R8 after reads", int'(fillCount), DEPTH);

    // R10 discard of a partial frame, remainder dropped
    pulseFlush();
    chk("R10 fillCount", int'(fillCount), 0);
    chk("R10 rdValid", int'(rdValid), 0);
    for (int i = 0; i < 5; i++) begin
      chk("R10 wrReady", int'(wrReady), 1);
      put(8'h55, (i == 4) ? 1'b1 : 1'b0);
      chk("R10 dropped", int'(fillCount), 0);
    end
    chk("R10 no frame", int'(txGo), 0);
    chk("R10 no data", int'(rdValid), 0);

    // R4 short frame released by its last byte
    cfgStart = 2'b10;
    for (int i = 0; i < 9; i++) put(pat(1, i), 1'b0);
    chk("R3 short not ready", int'(txGo), 0);
    cfgStart = 2'b00; #0.2;
    chk("R3 short below 16", int'(txGo), 0);
    cfgStart = 2'b10;
    put(pat(1, 9), 1'b1);
    chk("R4 txGo", int'(txGo), 1);
    chk("R8 fillCount 10", int'(fillCount), 10);

    // R7 rewind mid-frame, then full replay
    for (int i = 0; i < 4; i++) take("R6 frame1", pat(1, i), 1'b0);
    pulseRewind();
    chk("R7 fillCount", int'(fillCount), 10);
    for (int i = 0; i < 10; i++) take("R7 replay", pat(1, i), (i == 9) ? 1'b1 : 1'b0);
    chk("R8 read keeps", int'(fillCount), 10);
    chk("R6 no more", int'(rdValid), 0);
    pulseRewind();
    for (int i = 0; i < 10; i++) take("R7 second replay", pat(1, i), (i == 9) ? 1'b1 : 1'b0);
    pulseDone();
    chk("R8 done frees", int'(fillCount), 0);
    chk("R8 txGo after done", int'(txGo), 0);
    chk("R8 rdValid after done", int'(rdValid), 0);

    // R9 two complete frames, discard the head one
    for (int i = 0; i < 20; i++) put(pat(2, i), (i == 19) ? 1'b1 : 1'b0);
    for (int i = 0; i < 30; i++) put(pat(3, i), (i == 29) ? 1'b1 : 1'b0);
    chk("R8 two frames", int'(fillCount), 50);
    cfgStart = 2'b11; #0.2;
    chk("R4 complete head", int'(txGo), 1);
    take("R6 frame2", pat(2, 0), 1'b0);
    pulseFlush();
    chk("R9 fillCount", int'(fillCount), 30);
    for (int i = 0; i < 30; i++) take("R9 frame3", pat(3, i), (i == 29) ? 1'b1 : 1'b0);
    pulseDone();
    chk("R9 empty", int'(fillCount), 0);

    // R5 full-frame mode waits for the last byte
    for (int i = 0; i < 100; i++) put(pat(4, i), 1'b0);
    chk("R5 waiting", int'(txGo), 0);
    cfgStart = 2'b00; #0.2;
    chk("R3 cross 16", int'(txGo), 1);
    cfgStart = 2'b11;
    put(pat(4, 100), 1'b1);
    chk("R5 ready", int'(txGo), 1);
    take("R6 frame4", pat(4, 0), 1'b0);
    pulseDone();
    chk("R8 done unread", int'(fillCount), 0);
    chk("R1 dmaReq again", int'(dmaReq), 1);

    finishRun();
  end

endmodule